// File: doc/BRIEF.md
# Page Write Buffer with Timed Programming Cycle

This block sits between a two-wire serial protocol engine and a 2048 x 8 nonvolatile array. During a write transfer, the protocol engine first hands over an 11-bit start address. It then passes in data bytes one at a time. The block gathers these bytes into a sixteen-entry page buffer. The upper seven address bits pick the page. The low four bits give the position inside the page, and that position steps forward with each byte.

When the transfer ends with a stop condition, the protocol engine pulses a commit strobe. If at least one byte was gathered, the block starts a self-timed programming cycle whose length is a cycle-count parameter. In the first sixteen cycles it scans the page positions in ascending order. It issues one array write for each position that was loaded, and skips the rest, so unloaded locations keep their old contents. Busy stays high for the whole programming time. The protocol engine uses busy to refuse bus access, and the block ignores every input while busy is high.

Top module: `page_commit_buffer`

## Requirements
- R1: After reset, busy_o and arr_we_o are low.
- R2: A pulse on addr_load_i while idle sets the page to addr_i[10:4] and the in-page pointer to addr_i[3:0], and discards every byte gathered so far. In the same cycle it overrides commit_i and load_i, which are then ignored.
- R3: A load_i pulse while idle, with addr_load_i and commit_i low, stores load_data_i at in-page offset pointer. The pointer then becomes (pointer+1) mod 16, and the page bits never change.
- R4: Loading more than sixteen bytes wraps the pointer, so a later byte replaces the earlier byte at the same offset.
- R5: A commit_i pulse while idle, with addr_load_i low and at least one byte gathered, raises busy_o on the next cycle. busy_o then stays high for exactly PROG_CYCLES cycles.
- R6: A commit with no byte gathered starts nothing. busy_o stays low and no array write is issued.
- R7: During the first sixteen cycles of a programming cycle, the block issues exactly one write per loaded offset, in ascending offset order. The write address is {page, offset} and the data is the last byte loaded there. Offsets that were not loaded get no write.
- R8: While busy_o is high, addr_load_i, load_i and commit_i have no effect.
- R9: The gathered bytes are discarded in the same cycle that busy_o falls. A commit right after that, with no new load, starts nothing.
- R10: When commit_i and load_i are high in the same idle cycle, the commit is taken and the byte is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load_i | input | 1 | Start-address strobe |
| addr_i | input | 11 | Start address of the transfer |
| load_i | input | 1 | Data-byte strobe |
| load_data_i | input | 8 | Data byte |
| commit_i | input | 1 | Commit strobe, pulsed when the transfer ends with a stop |
| busy_o | output | 1 | High while a programming cycle runs |
| arr_we_o | output | 1 | Array write enable |
| arr_addr_o | output | 11 | Array write address |
| arr_wdata_o | output | 8 | Array write data |

## Verification
The hardest situation to reach from the ports is a set of inputs that arrive while a programming cycle is running and that the block must ignore. An ignored address load or byte load leaves no trace of its own on the outputs. The bench therefore fires an address load, a byte and a commit in the middle of a busy window. It then loads one more byte without a new address and commits. Because that write lands at the next offset of the original page, this shows the mid-cycle address was ignored. The immediate commit, which starts nothing, shows that the gathered set was cleared when busy fell.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
    localparam int DEF_ADDR_W     = 11;
    localparam int DEF_DATA_W     = 8;
    localparam int DEF_PAGE_BYTES = 16;

    function automatic int off_width(input int bytes);
        return (bytes > 1) ? $clog2(bytes) : 1;
    endfunction
endpackage

// File: rtl/pcb_page_store.sv
module pcb_page_store #(
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16,
    parameter int OFF_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic [OFF_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);
    logic [PAGE_BYTES-1:0] valid_d, valid_q;
    logic [DATA_W-1:0]     data_d [PAGE_BYTES];
    logic [DATA_W-1:0]     data_q [PAGE_BYTES];

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_entry
        always_comb begin
            valid_d[i] = valid_q[i];
            data_d[i]  = data_q[i];
            if (clr) begin
                valid_d[i] = 1'b0;
            end else if (wr_en && (wr_idx == OFF_W'(i))) begin
                valid_d[i] = 1'b1;
                data_d[i]  = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
                data_q[i]  <= '0;
            end else begin
                valid_q[i] <= valid_d[i];
                data_q[i]  <= data_d[i];
            end
        end
    end

    assign rd_data   = data_q[rd_idx];
    assign rd_valid  = valid_q[rd_idx];
    assign any_valid = |valid_q;
endmodule

// File: rtl/pcb_prog_timer.sv
module pcb_prog_timer #(
    parameter int PROG_CYCLES = 64,
    parameter int PAGE_BYTES  = 16,
    parameter int OFF_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic             done,
    output logic             scan_on,
    output logic [OFF_W-1:0] scan_idx
);
    localparam int CNT_W = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 2;
    localparam logic [CNT_W-1:0] LAST     = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] SCAN_END = CNT_W'(PAGE_BYTES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        done  = run && (cnt_q == LAST);
        cnt_d = (run && !done) ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign scan_on  = run && (cnt_q < SCAN_END);
    assign scan_idx = cnt_q[OFF_W-1:0];
endmodule

// File: rtl/page_commit_buffer.sv
module page_commit_buffer
    import pcb_pkg::*;
#(
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int DATA_W      = DEF_DATA_W,
    parameter int PAGE_BYTES  = DEF_PAGE_BYTES,
    parameter int PROG_CYCLES = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              commit_i,
    output logic              busy_o,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [DATA_W-1:0] arr_wdata_o
);
    localparam int OFF_W  = off_width(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic              busy;
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  ptr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic take_addr, take_commit, take_load, start;
    logic done, scan_on, rd_valid, any_valid;
    logic [OFF_W-1:0]  scan_idx;
    logic [DATA_W-1:0] rd_data;

    always_comb begin
        take_addr   = !ctl_q.busy && addr_load_i;
        take_commit = !ctl_q.busy && !addr_load_i && commit_i;
        take_load   = !ctl_q.busy && !addr_load_i && !commit_i && load_i;
        start       = take_commit && any_valid;

        ctl_d = ctl_q;
        if (take_addr) begin
            ctl_d.page = addr_i[ADDR_W-1:OFF_W];
            ctl_d.ptr  = addr_i[OFF_W-1:0];
        end
        if (take_load) ctl_d.ptr  = ctl_q.ptr + 1'b1;
        if (start)     ctl_d.busy = 1'b1;
        if (done)      ctl_d.busy = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    pcb_page_store #(
        .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(take_load), .wr_idx(ctl_q.ptr), .wr_data(load_data_i),
        .clr(take_addr || done),
        .rd_idx(scan_idx), .rd_data(rd_data), .rd_valid(rd_valid),
        .any_valid(any_valid)
    );

    pcb_prog_timer #(
        .PROG_CYCLES(PROG_CYCLES), .PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .run(ctl_q.busy),
        .done(done), .scan_on(scan_on), .scan_idx(scan_idx)
    );

    assign busy_o      = ctl_q.busy;
    assign arr_we_o    = scan_on && rd_valid;
    assign arr_addr_o  = {ctl_q.page, scan_idx};
    assign arr_wdata_o = rd_data;
endmodule

// File: rtl/page_commit_buffer_chk.sv
module page_commit_buffer_chk #(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 16,
    parameter int PROG_CYCLES = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_load_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              load_i,
    input logic [DATA_W-1:0] load_data_i,
    input logic              commit_i,
    input logic              busy_o,
    input logic              arr_we_o,
    input logic [ADDR_W-1:0] arr_addr_o,
    input logic [DATA_W-1:0] arr_wdata_o
);
    localparam int RW    = $clog2(PROG_CYCLES + 1);
    localparam int OFF_W = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;
    localparam logic [RW-1:0] RUN_LAST = RW'(PROG_CYCLES - 1);
    localparam logic [RW-1:0] SCAN_END = RW'(PAGE_BYTES);

    logic [RW-1:0] run_cnt;
    logic          filled;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            filled  <= 1'b0;
        end else begin
            run_cnt <= busy_o ? run_cnt + 1'b1 : '0;
            if (busy_o) begin
                if (run_cnt == RUN_LAST) filled <= 1'b0;
            end else if (addr_load_i) begin
                filled <= 1'b0;
            end else if (!commit_i && load_i) begin
                filled <= 1'b1;
            end
        end
    end

    assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && (run_cnt < RUN_LAST) |=> busy_o);
    assert_busy_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && (run_cnt == RUN_LAST) |=> !busy_o);
    assert_busy_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(commit_i) && !$past(addr_load_i));
    assert_empty_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && commit_i && !addr_load_i && !filled |=> !busy_o);
    assert_write_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> busy_o && (run_cnt < SCAN_END)
                     && (arr_addr_o[OFF_W-1:0] == run_cnt[OFF_W-1:0]));
    assert_page_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o && $past(arr_we_o) |->
            arr_addr_o[ADDR_W-1:OFF_W] == $past(arr_addr_o[ADDR_W-1:OFF_W]));
endmodule

bind page_commit_buffer page_commit_buffer_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr_load_i(addr_load_i), .addr_i(addr_i),
    .load_i(load_i), .load_data_i(load_data_i), .commit_i(commit_i),
    .busy_o(busy_o), .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o),
    .arr_wdata_o(arr_wdata_o)
);

// File: tb/sim_page_commit_buffer.sv
`timescale 1ns/1ps
module sim_page_commit_buffer;
    localparam int PROG = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_load_i = 1'b0;
    logic [10:0] addr_i = '0;
    logic        load_i = 1'b0;
    logic [7:0]  load_data_i = '0;
    logic        commit_i = 1'b0;
    logic        busy_o, arr_we_o;
    logic [10:0] arr_addr_o;
    logic [7:0]  arr_wdata_o;

    int checks = 0;
    int failures = 0;
    int wr_cnt = 0;
    logic [10:0] wr_addr [32];
    logic [7:0]  wr_data [32];

    always #10 clk = ~clk;

    page_commit_buffer #(.PROG_CYCLES(PROG)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_load_i(addr_load_i), .addr_i(addr_i),
        .load_i(load_i), .load_data_i(load_data_i), .commit_i(commit_i),
        .busy_o(busy_o), .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o),
        .arr_wdata_o(arr_wdata_o)
    );

    always @(negedge clk) begin
        if (arr_we_o) begin
            if (wr_cnt < 32) begin
                wr_addr[wr_cnt] = arr_addr_o;
                wr_data[wr_cnt] = arr_wdata_o;
            end
            wr_cnt = wr_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic op(input bit al, input logic [10:0] a, input bit ld,
                      input logic [7:0] d, input bit cm);
        addr_load_i = al; addr_i = a; load_i = ld; load_data_i = d; commit_i = cm;
        @(negedge clk);
        addr_load_i = 1'b0; load_i = 1'b0; commit_i = 1'b0;
    endtask

    task automatic wait_idle(output int len);
        len = 0;
        for (int i = 0; i < 2000 && busy_o; i++) begin
            len++;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic check_write(input int k, input logic [10:0] a,
                               input logic [7:0] d, input string req);
        chk(wr_addr[k] == a, req, int'(wr_addr[k]), int'(a));
        chk(wr_data[k] == d, req, int'(wr_data[k]), int'(d));
    endtask

    task automatic t_reset;
        chk(busy_o == 1'b0, "R1 busy", int'(busy_o), 0);
        chk(arr_we_o == 1'b0, "R1 we", int'(arr_we_o), 0);
    endtask

    task automatic t_single;
        int len;
        wr_cnt = 0;
        op(1, 11'h123, 0, 0, 0);
        op(0, 0, 1, 8'hA5, 0);
        op(0, 0, 0, 0, 1);
        chk(busy_o == 1'b1, "R5 busy rise", int'(busy_o), 1);
        wait_idle(len);
        chk(len == PROG, "R5 busy length", len, PROG);
        chk(wr_cnt == 1, "R7 write count", wr_cnt, 1);
        check_write(0, 11'h123, 8'hA5, "R7 single");
    endtask

    task automatic t_wrap;
        int len;
        wr_cnt = 0;
        op(1, 11'h3FE, 0, 0, 0);
        op(0, 0, 1, 8'h11, 0);
        op(0, 0, 1, 8'h22, 0);
        op(0, 0, 1, 8'h33, 0);
        op(0, 0, 0, 0, 1);
        wait_idle(len);
        chk(wr_cnt == 3, "R3 wrap count", wr_cnt, 3);
        check_write(0, 11'h3F0, 8'h33, "R3 wrap");
        check_write(1, 11'h3FE, 8'h11, "R3 wrap");
        check_write(2, 11'h3FF, 8'h22, "R3 wrap");
    endtask

    task automatic t_overflow;
        int len;
        wr_cnt = 0;
        op(1, 11'h200, 0, 0, 0);
        for (int i = 0; i < 18; i++) op(0, 0, 1, 8'(8'h10 + i), 0);
        op(0, 0, 0, 0, 1);
        wait_idle(len);
        chk(wr_cnt == 16, "R4 full page count", wr_cnt, 16);
        for (int k = 0; k < 16; k++) begin
            logic [7:0] e;
            e = (k < 2) ? 8'(8'h20 + k) : 8'(8'h10 + k);
            check_write(k, 11'(11'h200 + k), e, "R4 R7 overflow order");
        end
    endtask

    task automatic t_empty;
        wr_cnt = 0;
        op(1, 11'h050, 0, 0, 0);
        op(0, 0, 0, 0, 1);
        repeat (3) begin
            chk(busy_o == 1'b0, "R6 empty commit", int'(busy_o), 0);
            @(negedge clk);
        end
        chk(wr_cnt == 0, "R6 no writes", wr_cnt, 0);
    endtask

    task automatic t_busy_ignore;
        int len;
        wr_cnt = 0;
        op(1, 11'h400, 0, 0, 0);
        op(0, 0, 1, 8'h5A, 0);
        op(0, 0, 0, 0, 1);
        repeat (5) @(negedge clk);
        op(1, 11'h7F0, 0, 0, 0);
        op(0, 0, 1, 8'h77, 0);
        op(0, 0, 0, 0, 1);
        wait_idle(len);
        chk(len == PROG - 8, "R8 busy unchanged", len, PROG - 8);
        chk(wr_cnt == 1, "R8 write count", wr_cnt, 1);
        check_write(0, 11'h400, 8'h5A, "R8 original write");
        op(0, 0, 0, 0, 1);
        chk(busy_o == 1'b0, "R9 cleared on end", int'(busy_o), 0);
        wr_cnt = 0;
        op(0, 0, 1, 8'h33, 0);
        op(0, 0, 0, 0, 1);
        wait_idle(len);
        chk(wr_cnt == 1, "R8 count after", wr_cnt, 1);
        check_write(0, 11'h401, 8'h33, "R8 mid-cycle address ignored");
    endtask

    task automatic t_addr_prio;
        int len;
        wr_cnt = 0;
        op(1, 11'h100, 0, 0, 0);
        op(0, 0, 1, 8'h44, 0);
        op(1, 11'h180, 1, 8'h55, 0);
        op(0, 0, 0, 0, 1);
        chk(busy_o == 1'b0, "R2 discard", int'(busy_o), 0);
        op(0, 0, 1, 8'h66, 0);
        op(0, 0, 0, 0, 1);
        wait_idle(len);
        chk(wr_cnt == 1, "R2 count", wr_cnt, 1);
        check_write(0, 11'h180, 8'h66, "R2 priority");
    endtask

    task automatic t_commit_prio;
        int len;
        wr_cnt = 0;
        op(1, 11'h050, 0, 0, 0);
        op(0, 0, 1, 8'hA1, 0);
        op(0, 0, 1, 8'hB2, 1);
        wait_idle(len);
        chk(wr_cnt == 1, "R10 count", wr_cnt, 1);
        check_write(0, 11'h050, 8'hA1, "R10 commit wins");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_wrap();
        t_overflow();
        t_empty();
        t_busy_ignore();
        t_addr_prio();
        t_commit_prio();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule